// File: doc/BRIEF.md
# Internal Clock Source Selector

This block picks the device clock rate from a small internal oscillator system and decides which oscillators and which frequency multiplier must be running. Everything runs on the 8 MHz main oscillator clock. A free-running binary postscaler divides that clock, and a 3-bit rate code chooses a tap. The result is a one-cycle enable strobe at the chosen rate, so no derived clocks are created. At the lowest rate code a source bit picks the clock. With the bit set, the main clock divided by 256 is used. With the bit clear, rising edges of the separate 31 kHz RC clock are used, brought in through a synchronizer.

The same controls drive three registered enables. The main oscillator enable is high whenever a rate derived from the main oscillator is in use. The RC oscillator enable is high when the RC clock is the chosen source, or when any of four timing features needs it: the power-up timer, the fail-safe monitor, the watchdog and two-speed start-up. The effective multiplier enable follows the software request only when two conditions hold. The oscillator-mode configuration field must name an internal-oscillator primary mode, and the rate code must select 4 MHz or 8 MHz. The multiplier is four times, so its output never exceeds 32 MHz.

Top module: `intclk_select`

## Requirements
- R1: While `rst` is high, `clk_strobe`, `main_osc_en`, `rc_osc_en` and `pll_active` are all 0. Reset clears the postscaler counter and loads the rate register with its default, which is code 3'b100.
- R2: With `rate_sel` = 3'b111 (8 MHz), `clk_strobe` is high on every cycle.
- R3: With `rate_sel` = 3'b001 to 3'b110, `clk_strobe` pulses for one cycle every 2^(7-code) cycles. These rates are 125 kHz, 250 kHz, 500 kHz, 1 MHz, 2 MHz and 4 MHz.
- R4: With `rate_sel` = 3'b000 and `lf_from_main` = 1, `clk_strobe` pulses once every 256 cycles (31.25 kHz).
- R5: With `rate_sel` = 3'b000 and `lf_from_main` = 0, `clk_strobe` pulses once per rising edge of `rc_clk`. The pulses are spaced by the RC period counted in main clock cycles.
- R6: `main_osc_en` is 1 exactly when `rate_sel` is not 3'b000, or when it is 3'b000 with `lf_from_main` = 1. A change shows within two cycles.
- R7: `rc_osc_en` is 1 exactly when the RC clock is the chosen source, or when any of `pwrt_en`, `fscm_en`, `wdt_en` or `twospeed_en` is 1.
- R8: `pll_active` is 1 only when `pll_req` = 1, `osc_mode` is 4'b1001 or 4'b1000, and `rate_sel` is 3'b111 or 3'b110. Otherwise it is 0, whatever `pll_req` holds.
- R9: Out of reset, at least one of `main_osc_en` and `rc_osc_en` is always 1. Whenever `pll_active` is 1, `main_osc_en` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz main oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_clk | input | 1 | 31 kHz RC oscillator clock, asynchronous |
| rate_sel | input | 3 | Rate code, 3'b111 = 8 MHz down to 3'b000 = 31 kHz |
| lf_from_main | input | 1 | At code 000: 1 = main/256, 0 = RC clock |
| pll_req | input | 1 | Software request for the 4x multiplier |
| osc_mode | input | 4 | Oscillator-mode configuration field |
| pwrt_en | input | 1 | Power-up timer enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| wdt_en | input | 1 | Watchdog enabled |
| twospeed_en | input | 1 | Two-speed start-up enabled |
| clk_strobe | output | 1 | One-cycle enable at the selected rate |
| main_osc_en | output | 1 | Main oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable |
| pll_active | output | 1 | Effective multiplier enable |

## Verification
The hardest case to reach from the ports is the RC-sourced strobe. It needs a second clock that is asynchronous to the main clock and whose edges never fall on a main clock edge. The bench toggles `rc_clk` on a 160 ns half period, which falls between main edges. It selects code 000 with `lf_from_main` clear and measures the spacing of successive strobes, expecting 32 cycles. The 256-cycle divide is reached by waiting through several full counter wraps. The multiplier gate is driven through a grid of mode values and rate codes.

// File: rtl/intclk_pkg.sv
package intclk_pkg;
  typedef enum logic [2:0] {
    RATE_31K  = 3'd0,
    RATE_125K = 3'd1,
    RATE_250K = 3'd2,
    RATE_500K = 3'd3,
    RATE_1M   = 3'd4,
    RATE_2M   = 3'd5,
    RATE_4M   = 3'd6,
    RATE_8M   = 3'd7
  } rate_e;

  localparam logic [3:0] MODE_INTOSC_A = 4'b1001;
  localparam logic [3:0] MODE_INTOSC_B = 4'b1000;
  localparam int         NUM_FEAT      = 4;
endpackage

// File: rtl/intclk_rc_sync.sv
module intclk_rc_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rc_clk,
  output logic rc_rise
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], rc_clk};
  end

  assign rc_rise = sh[STAGES-2] & ~sh[STAGES-1];
endmodule

// File: rtl/intclk_postscaler.sv
module intclk_postscaler
  import intclk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] code,
  input  logic       lf_main,
  input  logic       rc_tick,
  output logic       strobe
);
  localparam int NCODE = 8;

  logic [CNT_W-1:0] cnt;
  logic [NCODE-1:0] tick;
  logic             use_rc;

  genvar i;
  generate
    for (i = 0; i < NCODE; i++) begin : g_tap
      localparam int               SH   = (i == 0) ? CNT_W : (NCODE - 1 - i);
      localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << SH) - 64'd1);
      assign tick[i] = ((cnt & MASK) == MASK);
    end
  endgenerate

  assign use_rc = (code == RATE_31K) && !lf_main;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      cnt    <= cnt + 1'b1;
      strobe <= use_rc ? rc_tick : tick[code];
    end
  end

  // R2
  direct_rate_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ($past(code) == 3'd7) |-> strobe);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    (strobe && code != 3'd7 && !use_rc && $past(code) == code && $past(lf_main) == lf_main)
      |=> !strobe);
endmodule

// File: rtl/intclk_osc_ctrl.sv
module intclk_osc_ctrl
  import intclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          code,
  input  logic                lf_main,
  input  logic                pll_req,
  input  logic [3:0]          mode,
  input  logic [NUM_FEAT-1:0] feat,
  output logic                main_en,
  output logic                rc_en,
  output logic                pll_en
);
  logic rc_src, mode_ok, rate_ok;

  assign rc_src  = (code == RATE_31K) && !lf_main;
  assign mode_ok = (mode == MODE_INTOSC_A) || (mode == MODE_INTOSC_B);
  assign rate_ok = (code == RATE_8M) || (code == RATE_4M);

  always_ff @(posedge clk) begin
    if (rst) begin
      main_en <= 1'b0;
      rc_en   <= 1'b0;
      pll_en  <= 1'b0;
    end else begin
      main_en <= !rc_src;
      rc_en   <= rc_src || (|feat);
      pll_en  <= pll_req && mode_ok && rate_ok;
    end
  end

  // R7
  rc_needed_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    !rc_en |-> !($past(feat) != '0));

  // R8
  pll_gate_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    pll_en |-> $past(pll_req));

  // R9
  pll_main_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    pll_en |-> main_en);

  // R9
  some_osc_chk: assert property (@(posedge clk) disable iff (rst || $past(rst))
    main_en || rc_en);
endmodule

// File: rtl/intclk_select.sv
module intclk_select
  import intclk_pkg::*;
#(
  parameter int         CNT_W       = 8,
  parameter int         SYNC_STAGES = 3,
  parameter logic [2:0] RESET_RATE  = 3'b100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rc_clk,
  input  logic [2:0] rate_sel,
  input  logic       lf_from_main,
  input  logic       pll_req,
  input  logic [3:0] osc_mode,
  input  logic       pwrt_en,
  input  logic       fscm_en,
  input  logic       wdt_en,
  input  logic       twospeed_en,
  output logic       clk_strobe,
  output logic       main_osc_en,
  output logic       rc_osc_en,
  output logic       pll_active
);
  logic [2:0] rate_q;
  logic       lf_q;
  logic       rc_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= RESET_RATE;
      lf_q   <= 1'b0;
    end else begin
      rate_q <= rate_sel;
      lf_q   <= lf_from_main;
    end
  end

  intclk_rc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .rc_clk(rc_clk), .rc_rise(rc_rise)
  );

  intclk_postscaler #(.CNT_W(CNT_W)) i_post (
    .clk(clk), .rst(rst), .code(rate_q), .lf_main(lf_q),
    .rc_tick(rc_rise), .strobe(clk_strobe)
  );

  intclk_osc_ctrl i_ctrl (
    .clk(clk), .rst(rst), .code(rate_q), .lf_main(lf_q),
    .pll_req(pll_req), .mode(osc_mode),
    .feat({twospeed_en, wdt_en, fscm_en, pwrt_en}),
    .main_en(main_osc_en), .rc_en(rc_osc_en), .pll_en(pll_active)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(clk_strobe || main_osc_en || rc_osc_en || pll_active));
endmodule

// File: tb/test_intclk_select.sv
module test_intclk_select;
  logic clk = 0, rst = 1, rc_clk = 0;
  logic [2:0] rate_sel = 3'b100;
  logic lf_from_main = 0, pll_req = 0;
  logic [3:0] osc_mode = 4'b0000;
  logic pwrt_en = 0, fscm_en = 0, wdt_en = 0, twospeed_en = 0;
  logic clk_strobe, main_osc_en, rc_osc_en, pll_active;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;
  always #160 rc_clk = ~rc_clk;

  intclk_select i_intclk_select (
    .clk(clk), .rst(rst), .rc_clk(rc_clk), .rate_sel(rate_sel),
    .lf_from_main(lf_from_main), .pll_req(pll_req), .osc_mode(osc_mode),
    .pwrt_en(pwrt_en), .fscm_en(fscm_en), .wdt_en(wdt_en),
    .twospeed_en(twospeed_en), .clk_strobe(clk_strobe),
    .main_osc_en(main_osc_en), .rc_osc_en(rc_osc_en), .pll_active(pll_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic interval(output int iv);
    int n = 0;
    while (!clk_strobe && n < 2000) begin @(negedge clk); n++; end
    n = 1;
    @(negedge clk);
    while (!clk_strobe && n < 2000) begin @(negedge clk); n++; end
    iv = n;
  endtask

  task automatic t_reset();
    settle(3);
    check(!clk_strobe && !main_osc_en && !rc_osc_en && !pll_active, "R1",
          {clk_strobe, main_osc_en, rc_osc_en, pll_active}, 0);
    rst = 0;
    settle(4);
  endtask

  task automatic t_direct();
    int hi = 0;
    rate_sel = 3'b111; lf_from_main = 0;
    settle(4);
    for (int k = 0; k < 20; k++) begin hi += clk_strobe; @(negedge clk); end
    check(hi == 20, "R2", hi, 20);
  endtask

  task automatic t_divided();
    int iv;
    for (int c = 1; c <= 6; c++) begin
      rate_sel = 3'(c);
      settle(4);
      interval(iv);
      check(iv == (1 << (7 - c)), "R3", iv, 1 << (7 - c));
      interval(iv);
      check(iv == (1 << (7 - c)), "R3", iv, 1 << (7 - c));
    end
  endtask

  task automatic t_lf_main();
    int iv;
    rate_sel = 3'b000; lf_from_main = 1;
    settle(4);
    interval(iv);
    check(iv == 256, "R4", iv, 256);
    interval(iv);
    check(iv == 256, "R4", iv, 256);
  endtask

  task automatic t_lf_rc();
    int iv;
    rate_sel = 3'b000; lf_from_main = 0;
    settle(8);
    interval(iv);
    check(iv == 32, "R5", iv, 32);
    interval(iv);
    check(iv == 32, "R5", iv, 32);
  endtask

  task automatic t_enables();
    rate_sel = 3'b000; lf_from_main = 0;
    {pwrt_en, fscm_en, wdt_en, twospeed_en} = 4'b0000;
    settle(3);
    check(!main_osc_en, "R6", main_osc_en, 0);
    check(rc_osc_en, "R7", rc_osc_en, 1);
    lf_from_main = 1;
    settle(3);
    check(main_osc_en, "R6", main_osc_en, 1);
    check(!rc_osc_en, "R7", rc_osc_en, 0);
    for (int f = 0; f < 4; f++) begin
      {pwrt_en, fscm_en, wdt_en, twospeed_en} = 4'(1 << f);
      settle(3);
      check(rc_osc_en, "R7 feature", rc_osc_en, 1);
    end
    {pwrt_en, fscm_en, wdt_en, twospeed_en} = 4'b0000;
    rate_sel = 3'b001;
    settle(3);
    check(main_osc_en && !rc_osc_en, "R6", {main_osc_en, rc_osc_en}, 2);
    check(main_osc_en || rc_osc_en, "R9", {main_osc_en, rc_osc_en}, 2);
  endtask

  task automatic t_pll();
    logic [3:0] modes [4] = '{4'b1001, 4'b1000, 4'b0010, 4'b1010};
    for (int m = 0; m < 4; m++) begin
      for (int c = 4; c < 8; c++) begin
        for (int r = 0; r < 2; r++) begin
          bit exp;
          osc_mode = modes[m]; rate_sel = 3'(c); pll_req = r[0];
          settle(3);
          exp = r[0] && (m < 2) && (c >= 6);
          check(pll_active == exp, "R8", pll_active, exp);
          if (pll_active) check(main_osc_en, "R9", main_osc_en, 1);
        end
      end
    end
    pll_req = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_direct();
    t_divided();
    t_lf_main();
    t_lf_rc();
    t_enables();
    t_pll();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule